// File: doc/BRIEF.md
# Edge-Aligned PWM Timer with Synchronized Reload

The block is a free-running up-counter that produces edge-aligned pulse-width modulation on a set of channels and raises an overflow interrupt once per period. Each period starts at a programmable initial count, runs up to a programmable modulo value and then wraps back to the initial count. Each channel output is high from the start of the period until the counter reaches that channel's compare value, and is low for the rest of the period.

Software reaches the block through a simple register port with write and read strobes. Writes to the modulo, initial-count and compare registers go only into shadow buffers. The live values take the buffered contents at a synchronization point, so no period ever runs with a half-updated setting. That point is either every counter maximum, when that option is enabled, or a single software request that clears itself. A sticky overflow flag holds the interrupt line high until software clears the flag with a read-then-write sequence. A typical use is a sine-table inverter: an interrupt handler writes the next duty value once per period, and the new value takes effect exactly at the following period boundary.

Top module: `pwm_sync_timer`

## Requirements
- R1: After reset the counter is stopped and holds 0. All live and buffered compare, modulo and initial values are 0. Every PWM output is low, the interrupt is low, and reads of control (address 0), status (address 1), sync (address 2), count (address 5) and compare buffer 0 (address 6) all return 0.
- R2: The counter advances only when the clock-select field, bits [1:0] of control, equals 01. With any other value (00, 10, 11) the count, readable at address 5, holds still.
- R3: While running, the counter counts up by one each clock from the live initial value to the live modulo value. On the clock after it reaches the modulo value it returns to the initial value (the wrap).
- R4: Each channel output is high while the count is below that channel's live compare value and low otherwise, which gives edge-aligned pulses that start at each wrap.
- R5: A live compare value of 0 keeps its output constantly low. A compare value above the modulo keeps it constantly high.
- R6: Writes to modulo (address 3), initial count (address 4) and compare n (address 6+n) change only the buffers, and reads of those addresses return the buffered value. While no synchronization point occurs, the outputs keep their previous pattern.
- R7: When the maximum-sync enable (sync bit 0) is 1, all buffers load into the live registers on the clock edge that wraps the counter. A new compare value therefore governs the whole of the next period.
- R8: Writing 1 to sync bit 1 requests a software synchronization. While the request is pending the bit reads back as 1. The bit clears itself when the load it requested takes place. While running, that load happens at the next wrap, even if the maximum-sync enable is 0.
- R9: The overflow flag (status bit 0) sets on every wrap and stays set. The interrupt output equals the flag AND the interrupt enable (control bit 2). Reading the status does not clear the flag.
- R10: A write of 0 to status bit 0 clears the flag only if an earlier read of status returned the flag as 1. A write of 0 without that read leaves the flag set.
- R11: While the counter is stopped, a pending software synchronization loads the buffers on the next clock and places the counter at the new initial value.
- R12: The flag sets on the same clock edge as the buffer load that happens at that wrap, so the first cycle that shows the flag also shows the new compare values on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms the flag clear) |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i, valid in the same cycle |
| pwm_o | output | NUM_CH | Edge-aligned PWM outputs |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
The bench builds the timer with an 8-bit counter and two channels. With modulo values between 4 and 9, a full period lasts only five to ten clocks, so many wraps, reloads and flag events fit into a short run. With an 8-bit counter, a compare value of 200 is safely above any modulo the bench uses, which exercises the always-high case. Each scenario first restarts the counter through the stopped-state software synchronization. This puts the counter at a known phase, so the bench can predict every output cycle by cycle from the requirements alone.

// File: rtl/pst_pkg.sv
// Package: shared register addresses, field positions and clock-select codes
// for the PWM sync timer. Assumes addresses are compared as unsigned ints.
package pst_pkg;
    localparam int REG_CTRL = 0;
    localparam int REG_STAT = 1;
    localparam int REG_SYNC = 2;
    localparam int REG_MOD  = 3;
    localparam int REG_INIT = 4;
    localparam int REG_CNT  = 5;
    localparam int REG_CMP0 = 6;

    localparam int CTRL_IE_BIT  = 2;
    localparam int SYNC_MAX_BIT = 0;
    localparam int SYNC_SW_BIT  = 1;

    typedef enum logic [1:0] {
        CLK_OFF  = 2'b00,
        CLK_SYS  = 2'b01,
        CLK_RSV2 = 2'b10,
        CLK_RSV3 = 2'b11
    } clk_sel_e;
endpackage

// File: rtl/pst_regs.sv
// Module: register port of the PWM sync timer. Holds control, sync settings,
// shadow buffers, the software sync request and the sticky overflow flag.
// Assumes CNT_W >= 3 so control fields fit in one data word.
module pst_regs
    import pst_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic                        rd_en_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [CNT_W-1:0]            wdata_i,
    output logic [CNT_W-1:0]            rdata_o,
    input  logic [CNT_W-1:0]            cnt_i,
    input  logic                        wrap_i,
    input  logic                        load_i,
    output logic                        run_o,
    output logic                        max_sync_o,
    output logic                        sw_pend_o,
    output logic                        ovf_flag_o,
    output logic                        irq_o,
    output logic [CNT_W-1:0]            mod_buf_o,
    output logic [CNT_W-1:0]            init_buf_o,
    output logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf_o
);
    int unsigned aidx;
    logic [1:0]  clk_sel_q;
    logic        irq_en_q;
    logic        clr_arm_q;
    logic        stat_wr, stat_rd, sync_wr;

    assign aidx    = int'(addr_i);
    assign stat_wr = wr_en_i && (aidx == REG_STAT);
    assign stat_rd = rd_en_i && (aidx == REG_STAT);
    assign sync_wr = wr_en_i && (aidx == REG_SYNC);
    assign run_o   = (clk_sel_q == CLK_SYS);
    assign irq_o   = ovf_flag_o && irq_en_q;

    // Control register and shadow buffers, written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel_q  <= CLK_OFF;
            irq_en_q   <= 1'b0;
            mod_buf_o  <= '0;
            init_buf_o <= '0;
            cmp_buf_o  <= '0;
        end else if (wr_en_i) begin
            if (aidx == REG_CTRL) begin
                clk_sel_q <= wdata_i[1:0];
                irq_en_q  <= wdata_i[CTRL_IE_BIT];
            end
            if (aidx == REG_MOD)  mod_buf_o  <= wdata_i;
            if (aidx == REG_INIT) init_buf_o <= wdata_i;
            for (int c = 0; c < NUM_CH; c++) begin
                if (aidx == REG_CMP0 + c) cmp_buf_o[c] <= wdata_i;
            end
        end
    end

    // Sync settings: max-sync enable and self-clearing software request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_sync_o <= 1'b0;
            sw_pend_o  <= 1'b0;
        end else begin
            if (sync_wr) max_sync_o <= wdata_i[SYNC_MAX_BIT];
            if (sync_wr && wdata_i[SYNC_SW_BIT]) sw_pend_o <= 1'b1;
            else if (load_i)                     sw_pend_o <= 1'b0;
        end
    end

    // Sticky overflow flag with read-as-one then write-zero clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag_o <= 1'b0;
            clr_arm_q  <= 1'b0;
        end else begin
            if (wrap_i)                                   ovf_flag_o <= 1'b1;
            else if (stat_wr && clr_arm_q && !wdata_i[0]) ovf_flag_o <= 1'b0;
            if (stat_wr)                     clr_arm_q <= 1'b0;
            else if (stat_rd && ovf_flag_o)  clr_arm_q <= 1'b1;
        end
    end

    // Read multiplexer, combinational on the address.
    always_comb begin
        rdata_o = '0;
        if (aidx == REG_CTRL) begin
            rdata_o[1:0]        = clk_sel_q;
            rdata_o[CTRL_IE_BIT] = irq_en_q;
        end
        if (aidx == REG_STAT) rdata_o[0] = ovf_flag_o;
        if (aidx == REG_SYNC) begin
            rdata_o[SYNC_MAX_BIT] = max_sync_o;
            rdata_o[SYNC_SW_BIT]  = sw_pend_o;
        end
        if (aidx == REG_MOD)  rdata_o = mod_buf_o;
        if (aidx == REG_INIT) rdata_o = init_buf_o;
        if (aidx == REG_CNT)  rdata_o = cnt_i;
        for (int c = 0; c < NUM_CH; c++) begin
            if (aidx == REG_CMP0 + c) rdata_o = cmp_buf_o[c];
        end
    end
endmodule

// File: rtl/pst_counter.sv
// Module: period counter with live modulo/initial registers and the
// synchronization-point decision. Assumes buffers are stable registers.
module pst_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             max_sync_i,
    input  logic             sw_pend_i,
    input  logic [CNT_W-1:0] mod_buf_i,
    input  logic [CNT_W-1:0] init_buf_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] mod_act_o,
    output logic             wrap_o,
    output logic             load_o
);
    logic [CNT_W-1:0] init_act_q;

    assign wrap_o = run_i && (cnt_o == mod_act_o);
    assign load_o = run_i ? (wrap_o && (max_sync_i || sw_pend_i)) : sw_pend_i;

    // Live modulo and initial values, taken from buffers at a sync point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_act_o  <= '0;
            init_act_q <= '0;
        end else if (load_o) begin
            mod_act_o  <= mod_buf_i;
            init_act_q <= init_buf_i;
        end
    end

    // Counter: count up, wrap to the initial value, restart on stopped load.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_o <= '0;
        else if (wrap_o)  cnt_o <= load_o ? init_buf_i : init_act_q;
        else if (run_i)   cnt_o <= cnt_o + 1'b1;
        else if (load_o)  cnt_o <= init_buf_i;
    end
endmodule

// File: rtl/pst_channel.sv
// Module: one PWM channel: live compare register and edge-aligned output.
// Assumes load_i is the shared synchronization strobe.
module pst_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cmp_buf_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             pwm_o
);
    logic [CNT_W-1:0] cmp_act_q;

    // Live compare value, taken from its buffer at a sync point.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_act_q <= '0;
        else if (load_i) cmp_act_q <= cmp_buf_i;
    end

    assign pwm_o = (cnt_i < cmp_act_q);
endmodule

// File: rtl/pwm_sync_timer.sv
// Module: top of the edge-aligned PWM timer with buffered, synchronized
// reload and a sticky overflow interrupt. Assumes one clock domain.
module pwm_sync_timer #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic [NUM_CH-1:0] pwm_o,
    output logic              irq_o
);
    logic                         run_w, max_sync_w, sw_pend_w, ovf_flag_w;
    logic                         wrap_w, load_w;
    logic [CNT_W-1:0]             cnt_w, mod_act_w, mod_buf_w, init_buf_w;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf_w;

    pst_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .cnt_i(cnt_w), .wrap_i(wrap_w), .load_i(load_w),
        .run_o(run_w), .max_sync_o(max_sync_w), .sw_pend_o(sw_pend_w),
        .ovf_flag_o(ovf_flag_w), .irq_o(irq_o),
        .mod_buf_o(mod_buf_w), .init_buf_o(init_buf_w), .cmp_buf_o(cmp_buf_w)
    );

    pst_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .run_i(run_w), .max_sync_i(max_sync_w),
        .sw_pend_i(sw_pend_w), .mod_buf_i(mod_buf_w), .init_buf_i(init_buf_w),
        .cnt_o(cnt_w), .mod_act_o(mod_act_w), .wrap_o(wrap_w), .load_o(load_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pst_channel #(.CNT_W(CNT_W)) ch_i (
            .clk(clk), .rst_n(rst_n), .load_i(load_w),
            .cmp_buf_i(cmp_buf_w[g]), .cnt_i(cnt_w), .pwm_o(pwm_o[g])
        );
    end
endmodule

// File: rtl/pst_checker.sv
// Module: assertion checker bound to pwm_sync_timer. Observes the port and
// the signals passed between its submodules.
module pst_checker
    import pst_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              run,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  mod_act,
    input logic              wrap,
    input logic              load,
    input logic              ovf_flag,
    input logic              irq,
    input logic              sw_pend,
    input logic              max_sync
);
    int unsigned aidx;
    assign aidx = int'(addr);

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != mod_act) |=> (cnt == $past(cnt) + 1'b1));

    // R7
    max_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && max_sync) |-> load);

    // R8
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !(wr_en && aidx == REG_SYNC)) |=> !sw_pend);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr_en && aidx == REG_STAT)) |=> ovf_flag);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && (aidx == REG_STAT || aidx == REG_CTRL))) |=> irq);

    // R12
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag);
endmodule

bind pwm_sync_timer pst_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i), .run(run_w),
    .cnt(cnt_w), .mod_act(mod_act_w), .wrap(wrap_w), .load(load_w),
    .ovf_flag(ovf_flag_w), .irq(irq_o), .sw_pend(sw_pend_w),
    .max_sync(max_sync_w)
);

// File: tb/pwm_sync_timer_tb.sv
// Bench: scoreboard style. Driver tasks push expected items into a queue;
// a monitor pops and compares them one time unit after each falling edge.
module pwm_sync_timer_tb_top;
    import pst_pkg::*;
    localparam int CW  = 8;
    localparam int NCH = 2;
    localparam int AW  = 4;
    localparam int K_PWM0 = 0, K_PWM1 = 1, K_IRQ = 2, K_RD = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [CW-1:0]  wdata = '0;
    logic [CW-1:0]  rdata;
    logic [NCH-1:0] pwm;
    logic           irq;

    pwm_sync_timer #(.CNT_W(CW), .NUM_CH(NCH), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm),
        .irq_o(irq)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    kind;
        int    exp;
        string req;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errs   = 0;
    int    ph     = 0;
    bit    done   = 1'b0;

    function automatic int observe(int kind);
        case (kind)
            K_PWM0:  return int'(pwm[0]);
            K_PWM1:  return int'(pwm[1]);
            K_IRQ:   return int'(irq);
            default: return int'(rdata);
        endcase
    endfunction

    // Monitor: compare every queued expectation against the live outputs.
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            int    act;
            it  = q.pop_front();
            act = observe(it.kind);
            checks++;
            if (act != it.exp) begin
                errs++;
                $display("FAIL %s: kind %0d actual %0d expected %0d at phase %0d",
                         it.req, it.kind, act, it.exp, ph);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        ph++;
    endtask

    task automatic expect_v(int kind, int exp, string req);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        q.push_back(it);
    endtask

    task automatic wr(int a, int d);
        addr  = a[AW-1:0];
        wdata = d[CW-1:0];
        wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, int exp, string req);
        addr  = a[AW-1:0];
        rd_en = 1'b1;
        expect_v(K_RD, exp, req);
        tick();
        rd_en = 1'b0;
    endtask

    // Stop, software-sync while stopped (R11), then run: count = init at ph 0.
    task automatic restart(int ctrl, int sync_bits);
        wr(REG_CTRL, ctrl & ~3);
        wr(REG_SYNC, sync_bits | 2);
        tick();
        wr(REG_CTRL, ctrl);
        ph = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        expect_v(K_PWM0, 0, "R1");
        expect_v(K_PWM1, 0, "R1");
        expect_v(K_IRQ, 0, "R1");
        rd(REG_CTRL, 0, "R1");
        rd(REG_STAT, 0, "R1");
        rd(REG_SYNC, 0, "R1");
        rd(REG_CNT, 0, "R1");
        rd(REG_CMP0, 0, "R1");

        // R3, R5, R11: init 2, modulo 6, compare 4 and 0
        wr(REG_INIT, 2);
        wr(REG_MOD, 6);
        wr(REG_CMP0, 4);
        wr(REG_CMP0 + 1, 0);
        rd(REG_MOD, 6, "R6");
        restart(1, 1);
        while (ph < 12) begin
            expect_v(K_PWM0, ((2 + ph % 5) < 4) ? 1 : 0, "R4");
            expect_v(K_PWM1, 0, "R5");
            rd(REG_CNT, 2 + ph % 5, "R3");
        end

        // R4, R5: init 0, modulo 9, compare 3 and 200 (> modulo)
        wr(REG_INIT, 0);
        wr(REG_MOD, 9);
        wr(REG_CMP0, 3);
        wr(REG_CMP0 + 1, 200);
        restart(1, 1);
        while (ph < 20) begin
            expect_v(K_PWM0, (ph % 10 < 3) ? 1 : 0, "R4");
            expect_v(K_PWM1, 1, "R5");
            tick();
        end

        // R6: buffered compare with no sync point keeps the old pattern
        wr(REG_SYNC, 0);
        wr(REG_CMP0, 7);
        rd(REG_CMP0, 7, "R6");
        while (ph < 43) begin
            expect_v(K_PWM0, (ph % 10 < 3) ? 1 : 0, "R6");
            tick();
        end
        // R7: enable max sync, new compare from the next wrap (phase 50)
        wr(REG_SYNC, 1);
        while (ph < 64) begin
            expect_v(K_PWM0, (ph < 50) ? ((ph % 10 < 3) ? 1 : 0)
                                       : ((ph % 10 < 7) ? 1 : 0), "R7");
            tick();
        end

        // R8: software sync while running, max sync off
        wr(REG_CMP0, 7);
        restart(1, 0);
        wr(REG_CMP0, 5);
        wr(REG_SYNC, 2);
        rd(REG_SYNC, 2, "R8");
        while (ph < 23) begin
            expect_v(K_PWM0, (ph < 10) ? ((ph % 10 < 7) ? 1 : 0)
                                       : ((ph % 10 < 5) ? 1 : 0), "R8");
            tick();
        end
        rd(REG_SYNC, 0, "R8");

        // R9, R10: flag is set from earlier wraps; stop with irq enable on
        wr(REG_CTRL, 4);
        expect_v(K_IRQ, 1, "R9");
        wr(REG_STAT, 0);
        expect_v(K_IRQ, 1, "R10");
        rd(REG_STAT, 1, "R10");
        tick();
        tick();
        expect_v(K_IRQ, 1, "R9");
        rd(REG_STAT, 1, "R9");
        wr(REG_STAT, 0);
        expect_v(K_IRQ, 0, "R10");
        rd(REG_STAT, 0, "R10");

        // R12: flag and new compare appear together at the wrap (phase 5)
        wr(REG_MOD, 4);
        wr(REG_CMP0, 1);
        restart(1, 1);
        wr(REG_CMP0, 3);
        while (ph < 10) begin
            expect_v(K_PWM0, (ph < 5) ? ((ph % 5 < 1) ? 1 : 0)
                                      : ((ph % 5 < 3) ? 1 : 0), "R12");
            expect_v(K_IRQ, 0, "R9");
            rd(REG_STAT, (ph >= 5) ? 1 : 0, "R12");
        end

        // R2: clock select 10 stops the counter; it holds at 1
        wr(REG_CTRL, 2);
        rd(REG_CNT, 1, "R2");
        tick();
        tick();
        rd(REG_CNT, 1, "R2");
        expect_v(K_PWM0, 1, "R2");
        rd(REG_CTRL, 2, "R2");

        tick();
        tick();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule